// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps a synchronous DRAM array refreshed on behalf of a memory controller. A free-running interval timer marks each period after which one AUTO REFRESH is owed; owed commands pile up in a small saturating count while the command arbiter has not yet handed over the bus. The block raises a bus request whenever something is owed or a self-refresh has been asked for. Once granted, it drives the clock-enable and command pins, issues the owed refreshes back to back at the refresh cycle spacing, and returns the bus only when the last one has completed.

The block also runs the low-power self-refresh protocol. When a self-refresh is requested and the bus is granted, it enters with clock-enable low and keeps it low for at least the minimum residency. It leaves only on a wake request, and then pads with NOPs for the exit time before issuing a fixed number of catch-up refreshes. A ready flag tells the rest of the controller when the array may carry normal traffic again. All time limits are parameters in whole clocks, rounded up from the nanosecond figures at the clock period in use.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While rst_ni is low and until the first owed refresh, cke_o=1, cs_no=ras_no=cas_no=we_no=1, busy_o=0, ready_o=1 and ref_req_o=0.
- R2: One refresh becomes owed every INTERVAL_CLKS clocks. The owed count saturates at DEBT_MAX. While the bus is not held, ref_req_o is 1 exactly when a refresh is owed or self_ref_req_i is 1.
- R3: grant_i takes effect only in a cycle where the block does not hold the bus and ref_req_o is 1. At any other time it has no effect.
- R4: An AUTO REFRESH is cke_o=1, cs_no=0, ras_no=0, cas_no=0, we_no=1. A grant with n refreshes owed and no self-refresh request yields exactly n such commands, the first one in the cycle after the grant is sampled.
- R5: Successive AUTO REFRESH commands are exactly T_RFC_CLKS clocks apart. busy_o stays 1 for exactly T_RFC_CLKS clocks per command issued.
- R6: While busy_o=0 the pins show deselect (cke_o=1, cs_no=1). While busy_o=1 outside self-refresh, every cycle without a command is a NOP (cke_o=1, cs_no=0, ras_no=cas_no=we_no=1).
- R7: If self_ref_req_i is 1 when the grant is taken, the block skips the owed refreshes. The next cycle carries the entry command (cke_o=0, cs_no=0, ras_no=0, cas_no=0, we_no=1), and the owed count is cleared.
- R8: cke_o stays low for max(T_RAS_CLKS, D) clocks when wake_i rises after the D-th low clock. Once the residency is met, cke_o rises in the clock after wake_i is sampled high.
- R9: After cke_o rises, exactly max(T_XSR_CLKS, 2) NOP clocks precede the next command.
- R10: After the exit NOPs, exactly CATCHUP_REFS AUTO REFRESH commands follow. ready_o is 0 from the entry command until the last catch-up spacing has ended, and it returns to 1 as busy_o falls.
- R11: During self-refresh, after the entry clock, cs_no=1 while cke_o stays low without a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Bus granted by the command arbiter |
| self_ref_req_i | input | 1 | Request to enter self-refresh |
| wake_i | input | 1 | Request to leave self-refresh |
| ref_req_o | output | 1 | Bus request to the arbiter |
| busy_o | output | 1 | Block currently owns the command pins |
| ready_o | output | 1 | Array usable for normal traffic |
| cke_o | output | 1 | Clock-enable level |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |

## Verification
The command pins, busy_o and ready_o all come from state, so each reacts one clock after a grant or wake is sampled. The bench drives inputs on falling edges and checks the very next falling edge for the first command. From there it counts clocks on the sampled pins: refresh gaps, busy length, cke_o low residency, exit NOP length and catch-up count. Each of these is compared with a figure worked out from the parameters. Interval expiry is tracked by a phase counter in the bench, and grants are placed mid-interval, so a one-clock offset against the design's timer cannot change the expected number of refreshes.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_set_t;

  localparam pin_set_t PINS_DESEL    = 5'b1_1111;
  localparam pin_set_t PINS_NOP      = 5'b1_0111;
  localparam pin_set_t PINS_AREF     = 5'b1_0001;
  localparam pin_set_t PINS_SR_ENTER = 5'b0_0001;
  localparam pin_set_t PINS_SR_HOLD  = 5'b0_1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AREF,
    ST_AREF_GAP,
    ST_SR_ENTER,
    ST_SR_STAY,
    ST_SR_EXIT
  } seq_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CLKS = 1040,
  parameter int DEBT_MAX      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic take_i,
  output logic pending_o
);
  localparam int CW = $clog2(INTERVAL_CLKS);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic [CW-1:0] tick_q;
  logic [DW-1:0] owed_q;
  logic          expire;

  assign expire    = (tick_q == '0);
  assign pending_o = (owed_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= CW'(INTERVAL_CLKS - 1);
      owed_q <= '0;
    end else if (clr_i) begin
      tick_q <= CW'(INTERVAL_CLKS - 1);
      owed_q <= '0;
    end else begin
      tick_q <= expire ? CW'(INTERVAL_CLKS - 1) : tick_q - 1'b1;
      case ({expire, take_i})
        2'b10:   if (owed_q != DW'(DEBT_MAX)) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assert_owed_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= DW'(DEBT_MAX));

  assert_take_needs_owed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (owed_q != '0));

endmodule

// File: rtl/ref_wait_cnt.sv
module ref_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/ref_sequencer.sv
module ref_sequencer
  import sdram_ref_pkg::*;
#(
  parameter int RFC     = 10,
  parameter int RAS     = 6,
  parameter int XSR     = 10,
  parameter int CATCHUP = 2,
  parameter int W       = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         grant_i,
  input  logic         sr_req_i,
  input  logic         wake_i,
  input  logic         pending_i,
  input  logic         wait_done_i,
  output logic         wait_load_o,
  output logic [W-1:0] wait_val_o,
  output logic         take_o,
  output logic         clr_o,
  output pin_set_t     pins_o,
  output logic         busy_o,
  output logic         ready_o,
  output logic         req_o
);
  localparam int CCW = $clog2(CATCHUP + 1);

  seq_state_e     state_q, state_d;
  logic           rec_q, rec_d;
  logic [CCW-1:0] catch_q, catch_d;

  always_comb begin
    state_d     = state_q;
    rec_d       = rec_q;
    catch_d     = catch_q;
    wait_load_o = 1'b0;
    wait_val_o  = '0;
    take_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (grant_i && (sr_req_i || pending_i)) begin
          if (sr_req_i) begin
            state_d = ST_SR_ENTER;
            rec_d   = 1'b1;
          end else begin
            state_d = ST_AREF;
          end
        end
      end
      ST_AREF: begin
        wait_load_o = 1'b1;
        wait_val_o  = W'(RFC - 2);
        state_d     = ST_AREF_GAP;
        if (rec_q && catch_q != '0) catch_d = catch_q - 1'b1;
        else                        take_o  = 1'b1;
      end
      ST_AREF_GAP: begin
        if (wait_done_i) begin
          if (rec_q && catch_q != '0) begin
            state_d = ST_AREF;
          end else begin
            rec_d = 1'b0;
            if (sr_req_i) begin
              state_d = ST_SR_ENTER;
              rec_d   = 1'b1;
            end else if (pending_i) begin
              state_d = ST_AREF;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      ST_SR_ENTER: begin
        wait_load_o = 1'b1;
        wait_val_o  = W'(RAS - 2);
        state_d     = ST_SR_STAY;
      end
      ST_SR_STAY: begin
        if (wait_done_i && wake_i) begin
          wait_load_o = 1'b1;
          wait_val_o  = W'(XSR - 1);
          catch_d     = CCW'(CATCHUP);
          state_d     = ST_SR_EXIT;
        end
      end
      ST_SR_EXIT: begin
        if (wait_done_i) state_d = ST_AREF;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rec_q   <= 1'b0;
      catch_q <= '0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_d;
      catch_q <= catch_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_AREF:     pins_o = PINS_AREF;
      ST_AREF_GAP: pins_o = PINS_NOP;
      ST_SR_ENTER: pins_o = PINS_SR_ENTER;
      ST_SR_STAY:  pins_o = PINS_SR_HOLD;
      ST_SR_EXIT:  pins_o = PINS_NOP;
      default:     pins_o = PINS_DESEL;
    endcase
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = !rec_q;
  assign req_o   = (state_q == ST_IDLE) && (sr_req_i || pending_i);
  assign clr_o   = (state_q == ST_SR_ENTER) || (state_q == ST_SR_STAY) ||
                   (state_q == ST_SR_EXIT);

  // Spacing and residency counters feed only the checks below
  logic [W-1:0] gap_q, low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '1;
      low_q <= '0;
    end else begin
      if (state_q == ST_AREF) gap_q <= W'(1);
      else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
      if (pins_o.cke)         low_q <= '0;
      else if (low_q != '1)   low_q <= low_q + 1'b1;
    end
  end

  assert_rfc_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AREF) |-> (gap_q >= W'(RFC)));

  assert_min_residency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_o.cke) |-> (low_q >= W'(RAS)));

  assert_grant_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !sr_req_i && !pending_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
  import sdram_ref_pkg::*;
#(
  parameter int INTERVAL_CLKS = 1040,
  parameter int DEBT_MAX      = 8,
  parameter int T_RFC_CLKS    = 10,
  parameter int T_RAS_CLKS    = 6,
  parameter int T_XSR_CLKS    = 10,
  parameter int CATCHUP_REFS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic self_ref_req_i,
  input  logic wake_i,
  output logic ref_req_o,
  output logic busy_o,
  output logic ready_o,
  output logic cke_o,
  output logic cs_no,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  localparam int RFC_EFF = (T_RFC_CLKS < 2) ? 2 : T_RFC_CLKS;
  localparam int RAS_EFF = (T_RAS_CLKS < 2) ? 2 : T_RAS_CLKS;
  localparam int XSR_EFF = (T_XSR_CLKS < 2) ? 2 : T_XSR_CLKS;
  localparam int CU_EFF  = (CATCHUP_REFS < 1) ? 1 : CATCHUP_REFS;
  localparam int MAXW_A  = (RFC_EFF > RAS_EFF) ? RFC_EFF : RAS_EFF;
  localparam int MAXW    = (MAXW_A > XSR_EFF) ? MAXW_A : XSR_EFF;
  localparam int W       = $clog2(MAXW + 1);

  logic         pending, take, clr, wait_load, wait_done;
  logic [W-1:0] wait_val;
  pin_set_t     pins;

  ref_interval_timer #(
    .INTERVAL_CLKS(INTERVAL_CLKS),
    .DEBT_MAX     (DEBT_MAX)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .take_i   (take),
    .pending_o(pending)
  );

  ref_wait_cnt #(.W(W)) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wait_load),
    .val_i (wait_val),
    .done_o(wait_done)
  );

  ref_sequencer #(
    .RFC    (RFC_EFF),
    .RAS    (RAS_EFF),
    .XSR    (XSR_EFF),
    .CATCHUP(CU_EFF),
    .W      (W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant_i),
    .sr_req_i   (self_ref_req_i),
    .wake_i     (wake_i),
    .pending_i  (pending),
    .wait_done_i(wait_done),
    .wait_load_o(wait_load),
    .wait_val_o (wait_val),
    .take_o     (take),
    .clr_o      (clr),
    .pins_o     (pins),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .req_o      (ref_req_o)
  );

  assign cke_o  = pins.cke;
  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;

  assert_entry_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_no && !ras_no && !cas_no && we_no));

  assert_exit_nop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (!cs_no && ras_no && cas_no && we_no));

  assert_not_ready_in_sr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !ready_o);

  assert_quiet_when_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && cke_o));

endmodule

// File: tb/sdram_refresh_mgr_bench.sv
`timescale 1ns/1ps
module sdram_refresh_mgr_bench;
  localparam int INT     = 400;
  localparam int DMAX    = 8;
  localparam int RFC     = 10;
  localparam int RAS     = 6;
  localparam int XSR     = 10;
  localparam int CU      = 2;
  localparam int WD_LIM  = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0, self_ref_req_i = 1'b0, wake_i = 1'b0;
  logic ref_req_o, busy_o, ready_o, cke_o, cs_no, ras_no, cas_no, we_no;

  int n_checks = 0;
  int n_err    = 0;
  int wd       = 0;
  int ph       = 0;
  int md       = 0;

  always #2 clk = ~clk;

  sdram_refresh_mgr #(
    .INTERVAL_CLKS(INT), .DEBT_MAX(DMAX), .T_RFC_CLKS(RFC),
    .T_RAS_CLKS(RAS), .T_XSR_CLKS(XSR), .CATCHUP_REFS(CU)
  ) u_sdram_refresh_mgr (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant_i),
    .self_ref_req_i(self_ref_req_i), .wake_i(wake_i),
    .ref_req_o(ref_req_o), .busy_o(busy_o), .ready_o(ready_o),
    .cke_o(cke_o), .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no)
  );

  function automatic bit is_aref();
    return cke_o && !cs_no && !ras_no && !cas_no && we_no;
  endfunction

  function automatic bit is_nop();
    return cke_o && !cs_no && ras_no && cas_no && we_no;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Owed-refresh model: one per interval, cleared in self-refresh
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!cke_o) begin
        ph <= 0;
        md <= 0;
      end else begin
        automatic int nd = md;
        if (is_aref() && ready_o && nd > 0) nd--;
        if (ph == INT - 1) begin
          ph <= 0;
          if (nd < DMAX) nd++;
        end else begin
          ph <= ph + 1;
        end
        md <= nd;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIM) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", wd, WD_LIM);
      summary();
    end
  end

  task automatic wait_ph(input int target);
    @(negedge clk);
    while (ph != target) @(negedge clk);
  endtask

  task automatic do_burst(input int n, input bit hold);
    int cnt = 0, busy_cnt = 0, last = 0;
    grant_i = 1'b1;
    @(negedge clk);
    if (!hold) grant_i = 1'b0;
    chk(is_aref(), "R4 first command after grant", int'(is_aref()), 1);
    while (busy_o) begin
      busy_cnt++;
      if (is_aref()) begin
        if (cnt > 0) chk(busy_cnt - last == RFC, "R5 refresh spacing", busy_cnt - last, RFC);
        last = busy_cnt;
        cnt++;
      end else begin
        chk(is_nop(), "R6 nop between commands", {cke_o, cs_no, ras_no, cas_no, we_no}, 5'b10111);
      end
      @(negedge clk);
    end
    chk(cnt == n, "R4 refresh count", cnt, n);
    chk(busy_cnt == n * RFC, "R5 busy length", busy_cnt, n * RFC);
    chk(cs_no && cke_o, "R6 deselect after release", {cke_o, cs_no}, 2'b11);
    if (hold) begin
      repeat (4) @(negedge clk);
      chk(!busy_o, "R3 grant held without request", int'(busy_o), 0);
    end
    grant_i = 1'b0;
  endtask

  task automatic sr_cycle(input int d);
    int low = 1, nops = 0, cnt = 0;
    self_ref_req_i = 1'b1;
    @(negedge clk);
    chk(ref_req_o, "R2 request on self-refresh ask", int'(ref_req_o), 1);
    grant_i = 1'b1;
    @(negedge clk);
    grant_i = 1'b0;
    self_ref_req_i = 1'b0;
    chk(!cke_o && !cs_no && !ras_no && !cas_no && we_no, "R7 entry command",
        {cke_o, cs_no, ras_no, cas_no, we_no}, 5'b00001);
    chk(!ready_o, "R10 not ready at entry", int'(ready_o), 0);
    if (low >= d) wake_i = 1'b1;
    @(negedge clk);
    while (!cke_o) begin
      chk(cs_no, "R11 inhibit during stay", int'(cs_no), 1);
      low++;
      if (low >= d) wake_i = 1'b1;
      @(negedge clk);
    end
    wake_i = 1'b0;
    chk(low == imax(d, RAS), "R8 cke low residency", low, imax(d, RAS));
    while (is_nop()) begin
      nops++;
      @(negedge clk);
    end
    chk(nops == imax(XSR, 2), "R9 exit nop clocks", nops, imax(XSR, 2));
    while (busy_o) begin
      if (is_aref()) cnt++;
      chk(!ready_o, "R10 not ready during catch-up", int'(ready_o), 0);
      @(negedge clk);
    end
    chk(cnt == CU, "R10 catch-up refresh count", cnt, CU);
    chk(ready_o, "R10 ready after catch-up", int'(ready_o), 1);
    chk(!ref_req_o, "R7 owed refreshes cleared", int'(ref_req_o), 0);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chk(cke_o && cs_no && ras_no && cas_no && we_no, "R1 pins in reset",
        {cke_o, cs_no, ras_no, cas_no, we_no}, 5'b11111);
    chk(!busy_o && ready_o && !ref_req_o, "R1 flags in reset",
        {busy_o, ready_o, ref_req_o}, 3'b010);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy_o && ready_o && !ref_req_o && cs_no, "R1 idle after reset",
        {busy_o, ready_o, ref_req_o, cs_no}, 4'b0101);

    // Grant with nothing owed must not take the bus
    wait_ph(100);
    grant_i = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!busy_o && cs_no, "R3 grant without request", int'(busy_o), 0);
    end
    grant_i = 1'b0;

    // One interval expires, no grant yet
    wait_ph(50);
    chk(ref_req_o && !busy_o, "R2 request after one interval", {ref_req_o, busy_o}, 2'b10);
    wait_ph(100);
    do_burst(md, 1'b0);

    // Saturation after many missed intervals
    repeat (11 * INT) @(negedge clk);
    wait_ph(120);
    chk(md == DMAX, "R2 bench model saturated", md, DMAX);
    do_burst(DMAX, 1'b1);

    // Random backlogs at random phases
    for (int i = 0; i < 6; i++) begin
      int k, p, exp_n;
      k = int'($urandom_range(1, 10));
      p = int'($urandom_range(60, 240));
      repeat (k * INT) @(negedge clk);
      wait_ph(p);
      exp_n = (md > DMAX) ? DMAX : md;
      if (exp_n == 0) begin
        grant_i = 1'b1;
        @(negedge clk);
        grant_i = 1'b0;
        chk(!busy_o, "R3 no backlog no bus", int'(busy_o), 0);
      end else begin
        do_burst(exp_n, i[0]);
      end
    end

    // Self-refresh, with and without a backlog, directed and random wake delays
    sr_cycle(1);
    repeat (2 * INT) @(negedge clk);
    wait_ph(80);
    sr_cycle(RAS);
    for (int i = 0; i < 3; i++) begin
      int pre, d;
      pre = int'($urandom_range(0, 3));
      d   = int'($urandom_range(1, 20));
      repeat (pre * INT) @(negedge clk);
      wait_ph(int'($urandom_range(60, 200)));
      sr_cycle(d);
    end

    // Normal refresh still works after self-refresh
    repeat (INT) @(negedge clk);
    wait_ph(100);
    chk(md >= 1, "R2 owed after interval following exit", md, 1);
    do_burst(md, 1'b0);

    summary();
  end

endmodule